// File: doc/BRIEF.md
# GPIO Transition Interrupt Controller

This block watches two ports of already synchronized general purpose inputs, one 8 bits wide and one 7 bits wide. When any bit changes in either direction, a sticky flag is raised for that bit. Software reads each port's flags through a read strobe, and the read clears them.

An enable mask for each bit decides which raised flags may drive the interrupt output. The interrupt can be a steady level or a train of repeating pulses, and its idle level is programmable. It can be placed on the top pin of port 1 or on the top pin of port 2. Whichever pin carries the interrupt loses its own flag, and that flag always reads as zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: A rising or a falling change on any input bit sets the matching status bit. The change is visible on the status outputs after the clock edge that sampled it. The status outputs are `p1_status` (port 1) and `p2_status` (port 2).
- R2: A read strobe (`rd_p1` or `rd_p2`) clears every status bit of its own port on the next clock edge. The other port is left as it is.
- R3: If a change arrives in the same cycle as a read of its port, the bit is still set after that edge.
- R4: While `irq_sel` is 0, or while no status bit with an enable bit of 1 is set, `irq_pin` sits at its idle level. That idle level equals `irq_idle_high`.
- R5: With `irq_sel`=1, `irq_on_p2`=0 selects port 1 bit 7 as the interrupt pin (`p1_irq_oe`=1), and `irq_on_p2`=1 selects port 2 bit 6 (`p2_irq_oe`=1). With `irq_sel`=0, both enables are 0.
- R6: The status bit of the pin currently carrying the interrupt reads 0, and changes on that input are not recorded.
- R7: In level mode (`irq_pulse`=0), `irq_pin` equals the inverse of `irq_idle_high` while an enabled status bit is set. It stays there until a read clears the flags.
- R8: In pulse mode (`irq_pulse`=1), the active level lasts PULSE_CYCLES cycles and repeats every REPEAT_CYCLES cycles. The train starts in the cycle the first enabled flag appears and stops once no enabled flag remains.
- R9: A further change on a bit whose flag is already set neither restarts the pulse train nor changes the status.
- R10: After reset, all status bits are 0 and `irq_pin` is at idle. Input values present while reset is released are not taken as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p1_pins | input | P1_W | Synchronized port 1 input values |
| p2_pins | input | P2_W | Synchronized port 2 input values |
| p1_en | input | P1_W | Port 1 interrupt enable mask |
| p2_en | input | P2_W | Port 2 interrupt enable mask |
| irq_sel | input | 1 | 1: shared pin acts as interrupt output |
| irq_on_p2 | input | 1 | 1: interrupt on port 2 top pin, 0: on port 1 top pin |
| irq_pulse | input | 1 | 1: pulse style, 0: level style |
| irq_idle_high | input | 1 | Idle level of the interrupt pin |
| rd_p1 | input | 1 | Port 1 status read strobe |
| rd_p2 | input | 1 | Port 2 status read strobe |
| p1_status | output | P1_W | Port 1 sticky change flags |
| p2_status | output | P2_W | Port 2 sticky change flags |
| irq_pin | output | 1 | Interrupt pin drive value |
| p1_irq_oe | output | 1 | Port 1 top pin carries the interrupt |
| p2_irq_oe | output | 1 | Port 2 top pin carries the interrupt |

## Verification
The assertions assume that the pin inputs are already synchronous to `clk` and that they hold steady while reset is asserted. Their change checks use the port 2 inputs while `irq_sel` is low, so that no flag is hidden from them. The stimulus drives every input on the falling clock edge. It changes one pin at a time, so each expected flag vector is a single shifted bit, and it changes the mode bits only while no flag is pending.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int P1_W          = 8,
  parameter int P2_W          = 7,
  parameter int PULSE_CYCLES  = 4,
  parameter int REPEAT_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P1_W-1:0] p1_pins,
  input  logic [P2_W-1:0] p2_pins,
  input  logic [P1_W-1:0] p1_en,
  input  logic [P2_W-1:0] p2_en,
  input  logic            irq_sel,
  input  logic            irq_on_p2,
  input  logic            irq_pulse,
  input  logic            irq_idle_high,
  input  logic            rd_p1,
  input  logic            rd_p2,
  output logic [P1_W-1:0] p1_status,
  output logic [P2_W-1:0] p2_status,
  output logic            irq_pin,
  output logic            p1_irq_oe,
  output logic            p2_irq_oe
);
  localparam int CW = $clog2(REPEAT_CYCLES + 1);

  logic            primed;
  logic [P1_W-1:0] prev1, st1, hide1, chg1;
  logic [P2_W-1:0] prev2, st2, hide2, chg2;
  logic [CW-1:0]   cnt;
  logic            pending, active;

  assign p1_irq_oe = irq_sel & ~irq_on_p2;
  assign p2_irq_oe = irq_sel & irq_on_p2;
  assign hide1 = {p1_irq_oe, {(P1_W-1){1'b0}}};
  assign hide2 = {p2_irq_oe, {(P2_W-1){1'b0}}};

  assign chg1 = primed ? (p1_pins ^ prev1) : '0;
  assign chg2 = primed ? (p2_pins ^ prev2) : '0;

  assign p1_status = st1 & ~hide1;
  assign p2_status = st2 & ~hide2;

  assign pending = irq_sel & ((|(p1_status & p1_en)) | (|(p2_status & p2_en)));
  assign active  = pending & (~irq_pulse | (cnt < CW'(PULSE_CYCLES)));
  assign irq_pin = active ^ irq_idle_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev1  <= '0;
      prev2  <= '0;
      st1    <= '0;
      st2    <= '0;
      cnt    <= '0;
    end else begin
      primed <= 1'b1;
      prev1  <= p1_pins;
      prev2  <= p2_pins;
      st1    <= ((st1 & ~{P1_W{rd_p1}}) | chg1) & ~hide1;
      st2    <= ((st2 & ~{P2_W{rd_p2}}) | chg2) & ~hide2;
      if (!pending || cnt == CW'(REPEAT_CYCLES - 1))
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int P1_W = 8,
  parameter int P2_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [P1_W-1:0] p1_pins,
  input logic [P2_W-1:0] p2_pins,
  input logic [P1_W-1:0] p1_en,
  input logic [P2_W-1:0] p2_en,
  input logic            irq_sel,
  input logic            irq_on_p2,
  input logic            irq_pulse,
  input logic            irq_idle_high,
  input logic            rd_p1,
  input logic            rd_p2,
  input logic [P1_W-1:0] p1_status,
  input logic [P2_W-1:0] p2_status,
  input logic            irq_pin,
  input logic            p1_irq_oe,
  input logic            p2_irq_oe
);
  logic [1:0] age;
  logic       warm, any_en;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  assign warm   = age >= 2'd2;
  assign any_en = (|(p1_status & p1_en)) | (|(p2_status & p2_en));

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !irq_sel && p2_pins != $past(p2_pins)) |=> (p2_status != '0));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rd_p2 && p2_pins == $past(p2_pins)) |=> (p2_status == '0));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_sel || !any_en) |-> (irq_pin == irq_idle_high));

  p_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_irq_oe, p2_irq_oe}) && (irq_sel || !(p1_irq_oe || p2_irq_oe)));

  p_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel && !irq_on_p2) |-> !p1_status[P1_W-1]);

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel && !irq_pulse && any_en) |-> (irq_pin != irq_idle_high));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_p1 |=> (($past(p1_status[P1_W-2:0]) & ~p1_status[P1_W-2:0]) == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.P1_W(P1_W), .P2_W(P2_W)) u_chk (.*);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int P = 2;
  localparam int R = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] p1_pins = '0, p1_en = '0, p1_status;
  logic [6:0] p2_pins = '0, p2_en = '0, p2_status;
  logic irq_sel = 0, irq_on_p2 = 0, irq_pulse = 0, irq_idle_high = 1;
  logic rd_p1 = 0, rd_p2 = 0;
  logic irq_pin, p1_irq_oe, p2_irq_oe;

  gpio_edge_irq #(.P1_W(8), .P2_W(7), .PULSE_CYCLES(P), .REPEAT_CYCLES(R)) i_gpio_edge_irq (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read_all();
    rd_p1 = 1; rd_p2 = 1;
    tick();
    rd_p1 = 0; rd_p2 = 0;
  endtask

  function automatic logic [31:0] stat();
    return {17'd0, p2_status, p1_status};
  endfunction

  task automatic flip(int i);
    if (i < 8) p1_pins[i] = ~p1_pins[i];
    else p2_pins[i-8] = ~p2_pins[i-8];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    p1_pins = 8'h5A;
    #1;
    check("R10 reset status", stat(), 0);
    check("R10 reset pin idle", irq_pin, 1);
    tick(); rst_n = 1;
    tick(); tick();
    check("R10 no false change", stat(), 0);
    p1_pins = 0; tick(); read_all();
    check("R2 clear after setup", stat(), 0);

    for (int i = 0; i < 15; i++) begin
      for (int d = 0; d < 2; d++) begin
        flip(i); tick();
        check("R1 single bit set", stat(), 32'd1 << i);
        check("R4 pin idle when unselected", irq_pin, 1);
        read_all();
        check("R2 read clears", stat(), 0);
      end
    end

    p2_pins[2] = 1; rd_p2 = 1; tick(); rd_p2 = 0;
    check("R3 set wins over read", stat(), 32'd1 << 10);
    p1_pins[1] = 1; rd_p2 = 1; tick(); rd_p2 = 0;
    check("R2 read other port kept", stat(), 32'd1 << 1);
    read_all();

    irq_sel = 1; irq_on_p2 = 0; tick();
    check("R5 oe p1", {p2_irq_oe, p1_irq_oe}, 2'b01);
    p1_pins[7] = 1; tick(); tick();
    check("R6 hidden bit p1", stat(), 0);
    irq_on_p2 = 1; tick();
    check("R5 oe p2", {p2_irq_oe, p1_irq_oe}, 2'b10);
    p2_pins[6] = 1; p1_pins[7] = 0; tick();
    check("R6 hidden bit p2", stat(), 32'd1 << 7);
    read_all();
    irq_sel = 0; tick();
    check("R5 oe none", {p2_irq_oe, p1_irq_oe}, 2'b00);

    irq_sel = 1; irq_on_p2 = 1; p1_en = 8'hF7; p2_en = 7'h3F;
    for (int pol = 0; pol < 2; pol++) begin
      irq_idle_high = pol[0]; irq_pulse = 0; tick();
      flip(3); tick();
      check("R4 masked bit no irq", irq_pin, pol);
      flip(2); tick();
      check("R7 level active", irq_pin, !pol);
      tick(); tick();
      check("R7 level holds", irq_pin, !pol);
      read_all();
      check("R7 level released", irq_pin, pol);
    end

    for (int pol = 0; pol < 2; pol++) begin
      irq_idle_high = pol[0]; irq_pulse = 1; tick();
      flip(9);
      for (int k = 0; k < 13; k++) begin
        tick();
        check("R8 pulse train", irq_pin, (((k % R) < P) ? 1 : 0) ^ pol);
        if (k == 3) flip(9);
      end
      check("R9 status unchanged", stat(), 32'd1 << 9);
      rd_p2 = 1; tick(); rd_p2 = 0;
      check("R8 train stops", irq_pin, pol);
      tick();
      check("R8 stays idle", irq_pin, pol);
    end

    finish_run();
  end
endmodule